// File: doc/BRIEF.md
# I2C Command-Word Transfer Engine

This block runs a complete I2C master transfer from a single 64-bit command word. A bus master first writes an optional 64-bit extension word and then writes the command word with its valid bit set. The command selects the direction, a byte count of 1 to 8, a 7-bit or 10-bit target address, and whether a 1- or 2-byte internal (register) address is written before the data phase. The engine then issues the START, the address bytes, any internal-address bytes, a repeated START where one is needed, the data bytes and the STOP on its own. When it finishes it clears the valid bit and raises a one-cycle done pulse.

Results come back through the same words. Read data lands in the data lanes it would have been written from. A transfer that fails clears the read flag and puts a bus state code in the low byte. Bit-level SCL/SDA timing is outside the block. The engine talks to a bus agent through a byte-level request/done handshake: one operation (START, repeated START, byte write, byte read, STOP) per request, with a NAK flag and a read byte returned with `bus_done_i`.

Top module: `i2c_cmd_engine`

## Requirements
- R1: Command word layout: bit 63 valid, bits 59:57 operation, bit 56 read, bit 55 size override (stored only), bits 54:52 byte count minus one, bit 50 two-byte internal address, bits 49:40 target address, bits 39:32 internal address, bits 31:0 data. A command write while valid is clear stores the word. The transfer starts only if bit 63 of the written word is 1.
- R2: At the end of every transfer, valid reads 0 and `done_irq_o` is high for exactly one cycle, in the same cycle that valid first reads 0. The bus request is never raised while valid is 0.
- R3: Bus operations on `bus_op_o`: 0 START, 1 repeated START, 2 write byte, 3 read byte, 4 STOP. Each request holds its operation and byte until `bus_done_i`. A plain 7-bit write issues START, `{addr[6:0],0}`, the data bytes, then STOP. At completion bit 56 reads 0 and the low byte reads 0x28.
- R4: The data bytes form D = {ext[31:0], cmd[31:0]}. For N bytes, bus byte k (k = 0 for the earliest) is D[8*(N-1-k) +: 8]: the earliest byte is in the highest used lane and the last byte is in cmd[7:0].
- R5: A plain 7-bit read sends `{addr[6:0],1}`. The master ACKs every read byte except the last, which it NAKs (`bus_mack_o` 1 = ACK). Received bytes are stored with the R4 lane rule, bit 56 stays 1, and fields above bit 31 are unchanged.
- R6: Operation 0 selects plain 7-bit addressing and operation 1 plain 10-bit addressing. In 10-bit mode the address goes out as `{5'b11110,addr[9:8],rw}` followed by `addr[7:0]`. A 10-bit read sends both bytes with rw = 0, then a repeated START and `{5'b11110,addr[9:8],1}` alone.
- R7: Operations 2 (7-bit) and 3 (10-bit) write an internal address after a write-direction address. With bit 50 clear this is cmd[39:32]. With bit 50 set, ext[39:32] goes first and cmd[39:32] second. A repeated START and the address with the data direction follow, then the data phase. A 10-bit write also resends the low address byte.
- R8: A NAK on an address byte ends the transfer with a STOP. Bit 56 is cleared and the low byte reads 0x48 if the NAKed byte carried rw = 1, otherwise 0x20.
- R9: A NAK on a written data byte or an internal-address byte ends the transfer with a STOP at once. Bit 56 is cleared and the low byte reads 0x30.
- R10: Command or extension writes that arrive while valid is set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 64 | Command word write data |
| ext_wr_i | input | 1 | Extension word write strobe |
| ext_wdata_i | input | 64 | Extension word write data |
| cmd_o | output | 64 | Current command word |
| ext_o | output | 64 | Current extension word |
| done_irq_o | output | 1 | One-cycle pulse at transfer end |
| bus_req_o | output | 1 | Bus operation requested |
| bus_op_o | output | 3 | Requested bus operation code |
| bus_wbyte_o | output | 8 | Byte to send for a write operation |
| bus_mack_o | output | 1 | For a read: 1 = ACK the byte, 0 = NAK |
| bus_done_i | input | 1 | Bus agent finished the operation |
| bus_nak_i | input | 1 | Target NAKed the written byte (with done) |
| bus_rbyte_i | input | 8 | Byte received by a read (with done) |

## Verification
The bench records every bus operation and compares the sequence with the one the requirements predict. It targets the direction bit used in each address phase, the repeated START in 10-bit reads and in combined transfers, and the order of two-byte internal addresses. A design that swapped the internal-address bytes, skipped the restart, or sent the low 10-bit address byte again after a read restart would produce a different sequence. Reads of six bytes cross from the command word into the extension word, so a lane-order slip shows up as misplaced data. NAKs are injected on the address, on a middle data byte and on an internal-address byte, which exposes a design that keeps sending or reports the wrong code. Writes made while busy are checked against the word that was launched.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int WORD_W    = 64;
  localparam int VALID_BIT = 63;
  localparam int OP_LSB    = 57;
  localparam int RD_BIT    = 56;
  localparam int SIZE_LSB  = 52;
  localparam int IA2_BIT   = 50;
  localparam int ADDR_LSB  = 40;
  localparam int IA_LSB    = 32;

  localparam logic [7:0] CODE_WR_OK   = 8'h28;
  localparam logic [7:0] CODE_WA_NAK  = 8'h20;
  localparam logic [7:0] CODE_RA_NAK  = 8'h48;
  localparam logic [7:0] CODE_WD_NAK  = 8'h30;

  typedef enum logic [2:0] {
    BUS_START   = 3'd0,
    BUS_RESTART = 3'd1,
    BUS_WRITE   = 3'd2,
    BUS_READ    = 3'd3,
    BUS_STOP    = 3'd4,
    BUS_NONE    = 3'd7
  } bus_op_e;

  typedef enum logic [1:0] {
    SRC_ADDR_HI,
    SRC_ADDR_LO,
    SRC_IA,
    SRC_DATA
  } byte_src_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADR1, ST_ADR2, ST_IA, ST_RSTART, ST_DATA, ST_STOP
  } seq_state_e;
endpackage

// File: rtl/i2c_cmd_lanes.sv
module i2c_cmd_lanes #(
  parameter int NBYTES = 8,
  localparam int IDX_W = $clog2(NBYTES),
  localparam int DW    = 8 * NBYTES
) (
  input  logic [DW-1:0]    data_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cap_i,
  input  logic [7:0]       cap_byte_i,
  output logic [7:0]       byte_o,
  output logic [DW-1:0]    data_o
);
  logic [IDX_W-1:0] lane;
  logic [NBYTES-1:0][7:0] pick;

  assign lane = last_i - idx_i;

  for (genvar l = 0; l < NBYTES; l++) begin : g_lane
    logic hit;
    assign hit = (lane == IDX_W'(l));
    assign pick[l] = hit ? data_i[8*l +: 8] : 8'h00;
    assign data_o[8*l +: 8] = (hit && cap_i) ? cap_byte_i : data_i[8*l +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    for (int l = 0; l < NBYTES; l++) byte_o = byte_o | pick[l];
  end
endmodule

// File: rtl/i2c_cmd_fsm.sv
module i2c_cmd_fsm
  import i2c_cmd_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             rd_i,
  input  logic             ten_i,
  input  logic             ia_i,
  input  logic             ia_two_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic             bus_done_i,
  input  logic             bus_nak_i,
  output logic             req_o,
  output bus_op_e          op_o,
  output byte_src_e        src_o,
  output logic             rw_o,
  output logic             ia_hi_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             mack_o,
  output logic             cap_o,
  output logic             fin_o,
  output logic             fail_o,
  output logic [7:0]       code_o
);
  seq_state_e state_q, after_addr;
  logic second_q, ia_hi_q, fail_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0] code_q;
  logic rw;

  // first phase is write-direction unless a plain 7-bit transfer
  assign rw = second_q ? rd_i : ((ia_i || ten_i) ? 1'b0 : rd_i);

  always_comb begin
    if (!second_q && ia_i)             after_addr = ST_IA;
    else if (!second_q && ten_i && rd_i) after_addr = ST_RSTART;
    else                               after_addr = ST_DATA;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
      ia_hi_q  <= 1'b0;
      fail_q   <= 1'b0;
      idx_q    <= '0;
      code_q   <= 8'h00;
    end else begin
      case (state_q)
        ST_IDLE: if (go_i) begin
          state_q  <= ST_START;
          second_q <= 1'b0;
          fail_q   <= 1'b0;
          idx_q    <= '0;
          code_q   <= 8'h00;
        end
        ST_START: if (bus_done_i) begin
          state_q <= ST_ADR1;
          ia_hi_q <= ia_two_i;
        end
        ST_RSTART: if (bus_done_i) begin
          state_q  <= ST_ADR1;
          second_q <= 1'b1;
        end
        ST_ADR1: if (bus_done_i) begin
          if (bus_nak_i) begin
            fail_q  <= 1'b1;
            code_q  <= rw ? CODE_RA_NAK : CODE_WA_NAK;
            state_q <= ST_STOP;
          end else if (ten_i && !(second_q && rd_i)) state_q <= ST_ADR2;
          else state_q <= after_addr;
        end
        ST_ADR2: if (bus_done_i) begin
          if (bus_nak_i) begin
            fail_q  <= 1'b1;
            code_q  <= CODE_WA_NAK;
            state_q <= ST_STOP;
          end else state_q <= after_addr;
        end
        ST_IA: if (bus_done_i) begin
          if (bus_nak_i) begin
            fail_q  <= 1'b1;
            code_q  <= CODE_WD_NAK;
            state_q <= ST_STOP;
          end else if (ia_hi_q) ia_hi_q <= 1'b0;
          else state_q <= ST_RSTART;
        end
        ST_DATA: if (bus_done_i) begin
          if (!rd_i && bus_nak_i) begin
            fail_q  <= 1'b1;
            code_q  <= CODE_WD_NAK;
            state_q <= ST_STOP;
          end else if (idx_q == last_i) begin
            if (!rd_i) code_q <= CODE_WR_OK;
            state_q <= ST_STOP;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_STOP: if (bus_done_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START:  op_o = BUS_START;
      ST_RSTART: op_o = BUS_RESTART;
      ST_ADR1, ST_ADR2, ST_IA: op_o = BUS_WRITE;
      ST_DATA:   op_o = rd_i ? BUS_READ : BUS_WRITE;
      ST_STOP:   op_o = BUS_STOP;
      default:   op_o = BUS_NONE;
    endcase
    unique case (state_q)
      ST_ADR1: src_o = SRC_ADDR_HI;
      ST_ADR2: src_o = SRC_ADDR_LO;
      ST_IA:   src_o = SRC_IA;
      default: src_o = SRC_DATA;
    endcase
  end

  assign req_o   = (state_q != ST_IDLE);
  assign rw_o    = rw;
  assign ia_hi_o = ia_hi_q;
  assign idx_o   = idx_q;
  assign mack_o  = (idx_q != last_i);
  assign cap_o   = (state_q == ST_DATA) && bus_done_i && rd_i;
  assign fin_o   = (state_q == ST_STOP) && bus_done_i;
  assign fail_o  = fail_q;
  assign code_o  = code_q;
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int NBYTES = 8,
  localparam int IDX_W = $clog2(NBYTES),
  localparam int DW    = 8 * NBYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [WORD_W-1:0] cmd_wdata_i,
  input  logic              ext_wr_i,
  input  logic [WORD_W-1:0] ext_wdata_i,
  output logic [WORD_W-1:0] cmd_o,
  output logic [WORD_W-1:0] ext_o,
  output logic              done_irq_o,
  output logic              bus_req_o,
  output logic [2:0]        bus_op_o,
  output logic [7:0]        bus_wbyte_o,
  output logic              bus_mack_o,
  input  logic              bus_done_i,
  input  logic              bus_nak_i,
  input  logic [7:0]        bus_rbyte_i
);
  logic [WORD_W-1:0] cmd_q, ext_q;
  logic irq_q, busy, go;
  logic rd, ten, ia, ia_two;
  logic [IDX_W-1:0] last;
  logic [9:0] addr;

  logic req, rw, ia_hi, mack, cap, fin, fail;
  bus_op_e op;
  byte_src_e src;
  logic [IDX_W-1:0] idx;
  logic [7:0] code, data_byte;
  logic [DW-1:0] data_cur, data_nxt;

  assign busy   = cmd_q[VALID_BIT];
  assign go     = cmd_wr_i && !busy && cmd_wdata_i[VALID_BIT];
  assign rd     = cmd_q[RD_BIT];
  assign ten    = cmd_q[OP_LSB];
  assign ia     = cmd_q[OP_LSB+1];
  assign ia_two = cmd_q[IA2_BIT];
  assign last   = cmd_q[SIZE_LSB +: IDX_W];
  assign addr   = cmd_q[ADDR_LSB +: 10];
  assign data_cur = {ext_q[DW/2-1:0], cmd_q[DW/2-1:0]};

  i2c_cmd_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni,
    .go_i(go), .rd_i(rd), .ten_i(ten), .ia_i(ia), .ia_two_i(ia_two),
    .last_i(last), .bus_done_i, .bus_nak_i,
    .req_o(req), .op_o(op), .src_o(src), .rw_o(rw), .ia_hi_o(ia_hi),
    .idx_o(idx), .mack_o(mack), .cap_o(cap), .fin_o(fin),
    .fail_o(fail), .code_o(code)
  );

  i2c_cmd_lanes #(.NBYTES(NBYTES)) u_lanes (
    .data_i(data_cur), .last_i(last), .idx_i(idx),
    .cap_i(cap), .cap_byte_i(bus_rbyte_i),
    .byte_o(data_byte), .data_o(data_nxt)
  );

  always_comb begin
    unique case (src)
      SRC_ADDR_HI: bus_wbyte_o = ten ? {5'b11110, addr[9:8], rw} : {addr[6:0], rw};
      SRC_ADDR_LO: bus_wbyte_o = addr[7:0];
      SRC_IA:      bus_wbyte_o = ia_hi ? ext_q[IA_LSB +: 8] : cmd_q[IA_LSB +: 8];
      default:     bus_wbyte_o = data_byte;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      ext_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= fin;
      if (ext_wr_i && !busy) ext_q <= ext_wdata_i;
      if (cmd_wr_i && !busy) cmd_q <= cmd_wdata_i;
      if (cap) begin
        cmd_q[DW/2-1:0] <= data_nxt[DW/2-1:0];
        ext_q[DW/2-1:0] <= data_nxt[DW-1:DW/2];
      end
      if (fin) begin
        cmd_q[VALID_BIT] <= 1'b0;
        if (fail) cmd_q[RD_BIT] <= 1'b0;
        if (fail || !rd) cmd_q[7:0] <= code;
      end
    end
  end

  assign cmd_o      = cmd_q;
  assign ext_o      = ext_q;
  assign done_irq_o = irq_q;
  assign bus_req_o  = req;
  assign bus_op_o   = op;
  assign bus_mack_o = mack;
endmodule

// File: rtl/i2c_cmd_engine_chk.sv
module i2c_cmd_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_wr_i,
  input logic        ext_wr_i,
  input logic [63:0] cmd_o,
  input logic [63:0] ext_o,
  input logic        done_irq_o,
  input logic        bus_req_o,
  input logic [2:0]  bus_op_o,
  input logic [7:0]  bus_wbyte_o,
  input logic        bus_done_i
);
  assert_irq_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> !cmd_o[63]);

  assert_irq_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);

  assert_no_req_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_o[63] |-> !bus_req_o);

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_done_i) |=> (bus_req_o && $stable(bus_op_o) && $stable(bus_wbyte_o)));

  assert_cmd_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[63] && cmd_wr_i) |=> (cmd_o[55:32] == $past(cmd_o[55:32])));

  assert_ext_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[63] && ext_wr_i) |=> (ext_o[63:32] == $past(ext_o[63:32])));
endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_wr_i(cmd_wr_i), .ext_wr_i(ext_wr_i),
  .cmd_o(cmd_o), .ext_o(ext_o), .done_irq_o(done_irq_o), .bus_req_o(bus_req_o),
  .bus_op_o(bus_op_o), .bus_wbyte_o(bus_wbyte_o), .bus_done_i(bus_done_i)
);

// File: tb/i2c_cmd_engine_test.sv
module i2c_cmd_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0, ext_wr = 1'b0;
  logic [63:0] cmd_wd = '0, ext_wd = '0;
  logic [63:0] cmd_o, ext_o;
  logic irq, req, mack;
  logic [2:0] op;
  logic [7:0] wbyte;
  logic done = 1'b0, nak = 1'b0;
  logic [7:0] rbyte = 8'h00;

  int n_chk = 0, n_bad = 0;

  localparam logic [2:0] OS = 3'd0, OR = 3'd1, OW = 3'd2, ORD = 3'd3, OP = 3'd4;

  logic [2:0] log_op [32];
  logic [7:0] log_by [32];
  logic       log_mk [32];
  int log_n = 0;
  logic [2:0] ex_op [32];
  logic [7:0] ex_by [32];
  logic       ex_mk [32];
  int ex_n = 0;
  logic [7:0] rx [8];
  int rx_n = 0;
  int nak_at = -1;

  always #10 clk = ~clk;

  i2c_cmd_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wd),
    .ext_wr_i(ext_wr), .ext_wdata_i(ext_wd),
    .cmd_o(cmd_o), .ext_o(ext_o), .done_irq_o(irq),
    .bus_req_o(req), .bus_op_o(op), .bus_wbyte_o(wbyte), .bus_mack_o(mack),
    .bus_done_i(done), .bus_nak_i(nak), .bus_rbyte_i(rbyte)
  );

  // byte-level bus agent
  initial begin
    forever begin
      @(negedge clk);
      if (req) begin
        if (log_n < 32) begin
          log_op[log_n] = op; log_by[log_n] = wbyte; log_mk[log_n] = mack;
        end
        log_n++;
        repeat (2) @(negedge clk);
        nak   = (op == OW) && (log_n - 1 == nak_at);
        rbyte = rx[rx_n % 8];
        if (op == ORD) rx_n++;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0; nak = 1'b0;
      end
    end
  end

  function automatic logic [63:0] mk(bit v, logic [2:0] o, bit rd, logic [2:0] sz,
                                     logic [9:0] a, logic [7:0] ia, bit ia2, logic [31:0] d);
    return {v, 3'b000, o, rd, 1'b1, sz, 1'b0, ia2, a, ia, d};
  endfunction

  task automatic chk(string req_tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic ex(logic [2:0] o, logic [7:0] b, logic m);
    ex_op[ex_n] = o; ex_by[ex_n] = b; ex_mk[ex_n] = m; ex_n++;
  endtask

  task automatic cmp_log(string req_tag);
    chk({req_tag, " op count"}, 64'(log_n), 64'(ex_n));
    for (int i = 0; i < ex_n && i < log_n; i++) begin
      chk({req_tag, " op"}, 64'(log_op[i]), 64'(ex_op[i]));
      if (ex_op[i] == OW)  chk({req_tag, " byte"}, 64'(log_by[i]), 64'(ex_by[i]));
      if (ex_op[i] == ORD) chk({req_tag, " mack"}, 64'(log_mk[i]), 64'(ex_mk[i]));
    end
  endtask

  task automatic prep(int nk);
    log_n = 0; ex_n = 0; rx_n = 0; nak_at = nk;
  endtask

  task automatic issue(logic [63:0] c, logic [63:0] e);
    @(negedge clk); ext_wd = e; ext_wr = 1'b1;
    @(negedge clk); ext_wr = 1'b0; cmd_wd = c; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wait_done(string req_tag);
    int t = 0;
    while (!irq && t < 3000) begin @(negedge clk); t++; end
    chk({req_tag, " completion pulse"}, 64'(irq), 64'd1);
    chk({req_tag, " valid cleared"}, 64'(cmd_o[63]), 64'd0);
    @(negedge clk);
    chk({req_tag, " pulse one cycle"}, 64'(irq), 64'd0);
  endtask

  task automatic t_reset;
    chk("R2 reset cmd", cmd_o, 64'd0);
    chk("R2 reset ext", ext_o, 64'd0);
    chk("R2 reset req/irq", {62'd0, req, irq}, 64'd0);
  endtask

  task automatic t_no_launch;
    logic [63:0] c;
    c = mk(0, 3'd0, 0, 3'd1, 10'h50, 8'h00, 0, 32'h1234);
    prep(-1);
    @(negedge clk); cmd_wd = c; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
    chk("R1 stored without valid", cmd_o, c);
    repeat (20) @(negedge clk);
    chk("R1 no bus activity", 64'(log_n), 64'd0);
  endtask

  task automatic t_wr7;
    logic [63:0] c, e;
    c = mk(1, 3'd0, 0, 3'd2, 10'h50, 8'h00, 0, 32'h00A1B2C3);
    prep(-1);
    issue(c, 64'd0);
    wait_done("R3");
    ex(OS, 0, 0); ex(OW, 8'hA0, 0); ex(OW, 8'hA1, 0); ex(OW, 8'hB2, 0); ex(OW, 8'hC3, 0); ex(OP, 0, 0);
    cmp_log("R3 R4 7-bit write");
    e = c; e[63] = 1'b0; e[7:0] = 8'h28;
    chk("R3 status word", cmd_o, e);
  endtask

  task automatic t_rd7;
    logic [63:0] c, e;
    c = mk(1, 3'd0, 1, 3'd5, 10'h21, 8'h00, 0, 32'h0);
    prep(-1);
    for (int i = 0; i < 6; i++) rx[i] = 8'h10 + 8'(i);
    issue(c, 64'hFFFF_0000_0000_0000);
    wait_done("R5");
    ex(OS, 0, 0); ex(OW, 8'h43, 0);
    for (int i = 0; i < 6; i++) ex(ORD, 0, (i != 5));
    ex(OP, 0, 0);
    cmp_log("R5 7-bit read");
    e = c; e[63] = 1'b0; e[31:0] = 32'h12131415;
    chk("R5 R4 cmd data lanes", cmd_o, e);
    chk("R4 ext data lanes", ext_o, 64'hFFFF_0000_0000_1011);
  endtask

  task automatic t_wr10;
    logic [63:0] c, e;
    c = mk(1, 3'd1, 0, 3'd0, 10'h2D5, 8'h00, 0, 32'h5A);
    prep(-1);
    issue(c, 64'd0);
    wait_done("R6");
    ex(OS, 0, 0); ex(OW, 8'hF4, 0); ex(OW, 8'hD5, 0); ex(OW, 8'h5A, 0); ex(OP, 0, 0);
    cmp_log("R6 10-bit write");
    e = c; e[63] = 1'b0; e[7:0] = 8'h28;
    chk("R6 status word", cmd_o, e);
  endtask

  task automatic t_rd10;
    logic [63:0] c, e;
    c = mk(1, 3'd1, 1, 3'd1, 10'h1AB, 8'h00, 0, 32'h0);
    prep(-1);
    rx[0] = 8'h77; rx[1] = 8'h88;
    issue(c, 64'd0);
    wait_done("R6");
    ex(OS, 0, 0); ex(OW, 8'hF2, 0); ex(OW, 8'hAB, 0); ex(OR, 0, 0); ex(OW, 8'hF3, 0);
    ex(ORD, 0, 1); ex(ORD, 0, 0); ex(OP, 0, 0);
    cmp_log("R6 10-bit read");
    e = c; e[63] = 1'b0; e[15:0] = 16'h7788;
    chk("R6 read data", cmd_o, e);
  endtask

  task automatic t_comb_rd;
    logic [63:0] c, e;
    c = mk(1, 3'd2, 1, 3'd0, 10'h50, 8'h34, 1, 32'h0);
    prep(-1);
    rx[0] = 8'h9C;
    issue(c, 64'h0000_0012_0000_0000);
    wait_done("R7");
    ex(OS, 0, 0); ex(OW, 8'hA0, 0); ex(OW, 8'h12, 0); ex(OW, 8'h34, 0); ex(OR, 0, 0);
    ex(OW, 8'hA1, 0); ex(ORD, 0, 0); ex(OP, 0, 0);
    cmp_log("R7 two-byte address read");
    e = c; e[63] = 1'b0; e[7:0] = 8'h9C;
    chk("R7 read data", cmd_o, e);
  endtask

  task automatic t_comb_wr;
    logic [63:0] c, e;
    c = mk(1, 3'd2, 0, 3'd1, 10'h3C, 8'h66, 0, 32'hDEAD);
    prep(-1);
    issue(c, 64'h0000_0099_0000_0000);
    wait_done("R7");
    ex(OS, 0, 0); ex(OW, 8'h78, 0); ex(OW, 8'h66, 0); ex(OR, 0, 0); ex(OW, 8'h78, 0);
    ex(OW, 8'hDE, 0); ex(OW, 8'hAD, 0); ex(OP, 0, 0);
    cmp_log("R7 one-byte address write");
    e = c; e[63] = 1'b0; e[7:0] = 8'h28;
    chk("R7 status word", cmd_o, e);
  endtask

  task automatic t_addr_nak;
    logic [63:0] c, e;
    c = mk(1, 3'd0, 1, 3'd3, 10'h21, 8'h00, 0, 32'h0);
    prep(1);
    issue(c, 64'd0);
    wait_done("R8");
    ex(OS, 0, 0); ex(OW, 8'h43, 0); ex(OP, 0, 0);
    cmp_log("R8 address NAK");
    e = c; e[63] = 1'b0; e[56] = 1'b0; e[7:0] = 8'h48;
    chk("R8 failure word", cmd_o, e);
  endtask

  task automatic t_data_nak;
    logic [63:0] c, e;
    c = mk(1, 3'd0, 0, 3'd2, 10'h50, 8'h00, 0, 32'h00A1B2C3);
    prep(3);
    issue(c, 64'd0);
    wait_done("R9");
    ex(OS, 0, 0); ex(OW, 8'hA0, 0); ex(OW, 8'hA1, 0); ex(OW, 8'hB2, 0); ex(OP, 0, 0);
    cmp_log("R9 data NAK");
    e = c; e[63] = 1'b0; e[7:0] = 8'h30;
    chk("R9 failure word", cmd_o, e);
  endtask

  task automatic t_ia_nak;
    logic [63:0] c, e;
    c = mk(1, 3'd2, 1, 3'd0, 10'h50, 8'h44, 0, 32'h0);
    prep(2);
    issue(c, 64'd0);
    wait_done("R9");
    ex(OS, 0, 0); ex(OW, 8'hA0, 0); ex(OW, 8'h44, 0); ex(OP, 0, 0);
    cmp_log("R9 internal address NAK");
    e = c; e[63] = 1'b0; e[56] = 1'b0; e[7:0] = 8'h30;
    chk("R9 failure word", cmd_o, e);
  endtask

  task automatic t_busy_ignore;
    logic [63:0] c, e;
    c = mk(1, 3'd0, 0, 3'd1, 10'h50, 8'h00, 0, 32'h1122);
    prep(-1);
    issue(c, 64'h0000_00AA_0000_0000);
    repeat (3) @(negedge clk);
    cmd_wd = mk(1, 3'd1, 1, 3'd7, 10'h3FF, 8'h55, 1, 32'hFFFF_FFFF); cmd_wr = 1'b1;
    ext_wd = 64'hFFFF_FFFF_FFFF_FFFF; ext_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0; ext_wr = 1'b0;
    wait_done("R10");
    ex(OS, 0, 0); ex(OW, 8'hA0, 0); ex(OW, 8'h11, 0); ex(OW, 8'h22, 0); ex(OP, 0, 0);
    cmp_log("R10 ignored write");
    e = c; e[63] = 1'b0; e[7:0] = 8'h28;
    chk("R10 cmd unchanged", cmd_o, e);
    chk("R10 ext unchanged", ext_o, 64'h0000_00AA_0000_0000);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_no_launch();
    t_wr7();
    t_rd7();
    t_wr10();
    t_rd10();
    t_comb_rd();
    t_comb_wr();
    t_addr_nak();
    t_data_nak();
    t_ia_nak();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule